// File: doc/BRIEF.md
# Indexed Block Configuration Target for a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus. It gives a host access to a small file of byte-wide configuration registers. A host writes by naming a start index and a byte count, then sending that many bytes. It reads by naming a start index, issuing a repeated START and switching to read. The target then returns a count byte, followed by the registers from the index upward. The number of bytes returned comes from a writable count register.

The 7-bit target address is one of three values. A tri-level select input chooses the value, and the block captures that input once, at the first rising edge of a power-good signal. SCL and SDA are oversampled on the system clock. SDA is driven open-drain: the block asserts an active-high pull-low enable and never drives a one.

The register bytes are presented flat to the surrounding logic, and two live status bits are merged into one register. The bus protocol paces every transfer, so the block has no valid/ready interface and no back-pressure of its own.

Top module: `cfg_smb_target`

## Requirements
- R1: The target address is 7'h6B when `addr_sel` is 2'b00 (low), 7'h6C when it is 2'b01 (mid), and 7'h6D when it is 2'b10 or 2'b11 (high). The eighth address bit is 0 for write and 1 for read.
- R2: `addr_sel` is captured at the first rising edge of `pwr_good` after reset. Later `pwr_good` edges and later `addr_sel` changes do not alter the address. Before the capture, no address is acknowledged.
- R3: An address byte that does not match is NACKed (SDA left high), and the rest of that transfer has no effect on any register.
- R4: A write transfer sends address+W, index N, count X, then data bytes. The first X data bytes are each ACKed and land in bytes N, N+1, and so on. Byte i of `cfg_bytes` sits at bits [8i+7:8i].
- R5: A data byte sent after the count is used up is NACKed and is not stored.
- R6: A read transfer sends address+W, index N, repeated START, then address+R. The target returns a count byte {3'b000, C}, where C is byte 7 bits [4:0]. It then returns bytes N, N+1, ... for C data bytes, and 8'hFF for any byte the host requests after those.
- R7: Byte 7 resets to 8'h08. Only its bits [4:0] are writable, and bits [7:5] read 0.
- R8: Byte 5 always reads 8'h11 and byte 17 always reads 8'h00. Writes to them are acknowledged but ignored.
- R9: Byte 1 bits [7:6] always show the live `stat_in[1:0]`. Writes to those bits are ignored, and bits [5:0] are writable.
- R10: A STOP in the middle of a byte returns the target to idle, and a repeated START in the middle of a byte returns it to the address phase. In both cases the partial byte is never stored.
- R11: Indices from 19 up (outside the file) are ACKed on write but store nothing, and they read 8'h00. The index advances after every data byte on both reads and writes.
- R12: After reset `sda_drive_low` is 0. All other bytes reset to 8'h00. The target changes `sda_drive_low` only while SCL is low, except when it releases on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Power-good; its first rising edge captures `addr_sel` |
| addr_sel | input | 2 | Tri-level address select: 00 low, 01 mid, 1x high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| stat_in | input | 2 | Live status bits shown in byte 1 bits [7:6] |
| cfg_bytes | output | NREG*8 (152) | All register bytes, byte i at [8i+7:8i] |

## Verification
The hardest state to reach from the ports is a transfer cut off partway through a byte. Here a STOP or repeated START arrives after only a few data bits have been clocked in, and the bench must show that the half-byte never reaches the register file. The host bit tasks drive single bits, so a scenario sends a complete byte followed by three or four loose bits. It then issues STOP, or a START followed by a read, and checks the neighbouring registers and the count byte that comes back. The address capture can happen only once per reset, so each select level is tested after its own reset and power-good pulse.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_IDX,
    ST_CNT,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_IGNORE
  } smb_st_e;

  localparam int IDX_STAT = 1;
  localparam int IDX_ID   = 5;
  localparam int IDX_CNT  = 7;
  localparam int IDX_ZERO = 17;

  localparam logic [7:0] ID_VALUE  = 8'h11;
  localparam logic [7:0] CNT_RESET = 8'h08;

  localparam logic [6:0] ADDR_LO  = 7'h6B;
  localparam logic [6:0] ADDR_MID = 7'h6C;
  localparam logic [6:0] ADDR_HI  = 7'h6D;

  // writable bits of register byte i
  function automatic logic [7:0] reg_wmask(input int i);
    if (i == IDX_STAT) return 8'h3F;
    if (i == IDX_ID)   return 8'h00;
    if (i == IDX_CNT)  return 8'h1F;
    if (i == IDX_ZERO) return 8'h00;
    return 8'hFF;
  endfunction

  // reset value, and the fixed value of bits that are not writable
  function automatic logic [7:0] reg_rstval(input int i);
    if (i == IDX_ID)  return ID_VALUE;
    if (i == IDX_CNT) return CNT_RESET;
    return 8'h00;
  endfunction

  function automatic logic [6:0] addr_decode(input logic [1:0] sel);
    case (sel)
      2'b00:   return ADDR_LO;
      2'b01:   return ADDR_MID;
      default: return ADDR_HI;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/smb_addr_latch.sv
module smb_addr_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] addr_sel,
  output logic [6:0] dev_addr,
  output logic       addr_valid
);
  import cfg_smb_pkg::*;

  logic pg_s1, pg_s2, pg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_s1      <= 1'b0;
      pg_s2      <= 1'b0;
      pg_d       <= 1'b0;
      dev_addr   <= ADDR_LO;
      addr_valid <= 1'b0;
    end else begin
      pg_s1 <= pwr_good;
      pg_s2 <= pg_s1;
      pg_d  <= pg_s2;
      if (pg_s2 && !pg_d && !addr_valid) begin
        dev_addr   <= addr_decode(addr_sel);
        addr_valid <= 1'b1;
      end
    end
  end

  // R2: once captured, the address never moves
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  input  logic       addr_valid,
  input  logic [7:0] rd_data,
  input  logic [4:0] rd_cnt,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  import cfg_smb_pkg::*;

  smb_st_e    state, after_st;
  logic [7:0] sh;
  logic [2:0] bitcnt;
  logic       full;
  logic       first_tx;
  logic       host_ack;
  logic [7:0] idx;
  logic [7:0] wcnt;
  logic [4:0] rleft;
  logic [7:0] txb;

  assign rd_addr = idx;

  always_comb begin
    if (first_tx)        txb = {3'b000, rd_cnt};
    else if (rleft != 0) txb = rd_data;
    else                 txb = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      after_st <= ST_IDLE;
      sh       <= '0;
      bitcnt   <= '0;
      full     <= 1'b0;
      first_tx <= 1'b0;
      host_ack <= 1'b0;
      idx      <= '0;
      wcnt     <= '0;
      rleft    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_CNT, ST_WDAT: begin
            if (scl_rise && !full) begin
              sh     <= {sh[6:0], sda_q};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full   <= 1'b0;
              bitcnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (addr_valid && sh[7:1] == dev_addr) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    if (sh[0]) begin
                      after_st <= ST_TX;
                      first_tx <= 1'b1;
                    end else begin
                      after_st <= ST_IDX;
                    end
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                ST_IDX: begin
                  idx      <= sh;
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  after_st <= ST_CNT;
                end
                ST_CNT: begin
                  wcnt     <= sh;
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  after_st <= ST_WDAT;
                end
                default: begin
                  if (wcnt != 0) begin
                    wr_en    <= 1'b1;
                    wr_addr  <= idx;
                    wr_data  <= sh;
                    idx      <= idx + 8'd1;
                    wcnt     <= wcnt - 8'd1;
                    sda_oe   <= 1'b1;
                    state    <= ST_ACK;
                    after_st <= ST_WDAT;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= after_st;
              if (after_st == ST_TX) begin
                sh     <= txb;
                sda_oe <= ~txb[7];
                bitcnt <= '0;
                if (first_tx) begin
                  first_tx <= 1'b0;
                  rleft    <= rd_cnt;
                end else if (rleft != 0) begin
                  idx   <= idx + 8'd1;
                  rleft <= rleft - 5'd1;
                end
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_HACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                state  <= ST_TX;
                sh     <= txb;
                sda_oe <= ~txb[7];
                bitcnt <= '0;
                if (rleft != 0) begin
                  idx   <= idx + 8'd1;
                  rleft <= rleft - 5'd1;
                end
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: the target only starts pulling SDA while SCL is low
  p_oe_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R12: releases with SCL high only come from a bus condition
  p_oe_fall_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_q || $past(start_det) || $past(stop_det)));

  // R10: STOP returns to idle with SDA released
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

  // R10: START (first or repeated) lands in the address phase
  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R4: register writes only come out of the data phase
  p_wr_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(state) == ST_WDAT));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NREG = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_addr,
  input  logic [1:0]      stat_in,
  output logic [7:0]      rd_data,
  output logic [4:0]      rd_cnt,
  output logic [NREG*8-1:0] cfg_bytes
);
  import cfg_smb_pkg::*;

  logic [7:0] rb [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [7:0] WM = reg_wmask(g);
    localparam logic [7:0] RV = reg_rstval(g);
    localparam logic [7:0] GA = 8'(g);
    logic [7:0] store;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          store <= RV & WM;
      else if (wr_en && wr_addr == GA)     store <= wr_data & WM;
    end

    if (g == IDX_STAT) begin : g_live
      assign rb[g] = (store & WM) | (RV & ~WM) | {stat_in, 6'b0};
    end else begin : g_plain
      assign rb[g] = (store & WM) | (RV & ~WM);
    end

    assign cfg_bytes[g*8 +: 8] = rb[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == 8'(i)) rd_data = rb[i];
    end
  end

  assign rd_cnt = rb[IDX_CNT][4:0];

  // R8: a write aimed at the identity byte leaves it untouched
  p_id_const_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'(IDX_ID)) |=> $stable(rb[IDX_ID]));

endmodule

// File: rtl/cfg_smb_target.sv
module cfg_smb_target #(
  parameter int NREG        = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [1:0]        addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  input  logic [1:0]        stat_in,
  output logic [NREG*8-1:0] cfg_bytes
);

  logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_addr;
  logic       addr_valid;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [4:0] rd_cnt;
  logic       wr_en;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_addr_latch u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .addr_sel   (addr_sel),
    .dev_addr   (dev_addr),
    .addr_valid (addr_valid)
  );

  smb_bit_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_q      (scl_q),
    .sda_q      (sda_q),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .dev_addr   (dev_addr),
    .addr_valid (addr_valid),
    .rd_data    (rd_data),
    .rd_cnt     (rd_cnt),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sda_oe     (sda_drive_low)
  );

  cfg_regfile #(.NREG(NREG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .stat_in   (stat_in),
    .rd_data   (rd_data),
    .rd_cnt    (rd_cnt),
    .cfg_bytes (cfg_bytes)
  );

endmodule

// File: tb/tb_cfg_smb_target.sv
`timescale 1ns/1ps
module tb_cfg_smb_target;

  localparam int NREG = 19;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic [1:0] stat_in = 2'b00;
  logic h_scl = 1'b1;
  logic h_sda = 1'b1;
  logic sda_drive_low;
  logic [NREG*8-1:0] cfg_bytes;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int r12_viol = 0;

  logic [7:0] wbuf [8];
  logic       wack [8];
  logic [7:0] rbuf [8];
  logic [7:0] rcount;
  logic       addr_ack;

  always #2 clk = ~clk;

  assign sda_line = h_sda & ~sda_drive_low;

  cfg_smb_target #(.NREG(NREG)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good      (pwr_good),
    .addr_sel      (addr_sel),
    .scl_i         (h_scl),
    .sda_i         (sda_line),
    .sda_drive_low (sda_drive_low),
    .stat_in       (stat_in),
    .cfg_bytes     (cfg_bytes)
  );

  // R12 monitor: target output must not move while SCL is held high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && h_scl && prev_scl && sda_drive_low != prev_oe) r12_viol++;
    prev_oe  <= sda_drive_low;
    prev_scl <= h_scl;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input int i);
    return cfg_bytes[i*8 +: 8];
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic host_start();
    h_sda = 1'b1; wq();
    h_scl = 1'b1; wq();
    h_sda = 1'b0; wq();
    h_scl = 1'b0; wq();
  endtask

  task automatic host_stop();
    h_sda = 1'b0; wq();
    h_scl = 1'b1; wq();
    h_sda = 1'b1; wq();
  endtask

  task automatic host_bit(input logic b, output logic s);
    h_sda = b; wq();
    h_scl = 1'b1; wq();
    s = sda_line; wq();
    h_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) host_bit(b[i], s);
    host_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      host_bit(1'b1, s);
      b[i] = s;
    end
    host_bit(nack, s);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0; pwr_good = 1'b0; addr_sel = sel;
    h_scl = 1'b1; h_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_pg();
    pwr_good = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    host_start();
    send_byte({a, 1'b0}, ack);
    host_stop();
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] idx,
                           input logic [7:0] cnt, input int n);
    logic k;
    host_start();
    send_byte({a, 1'b0}, addr_ack);
    send_byte(idx, k);
    send_byte(cnt, k);
    for (int i = 0; i < n; i++) send_byte(wbuf[i], wack[i]);
    host_stop();
  endtask

  task automatic blk_read(input logic [6:0] a, input logic [7:0] idx, input int n);
    logic k;
    host_start();
    send_byte({a, 1'b0}, k);
    send_byte(idx, k);
    host_start();
    send_byte({a, 1'b1}, addr_ack);
    recv_byte(n == 0, rcount);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    host_stop();
  endtask

  task automatic t_reset();
    logic ok;
    do_reset(2'b00);
    chk("R12 sda released", sda_drive_low, 0);
    chk("R7 count reset", cbyte(7), 8'h08);
    chk("R8 id reset", cbyte(5), 8'h11);
    chk("R12 byte0 reset", cbyte(0), 8'h00);
    chk("R12 byte18 reset", cbyte(18), 8'h00);
    probe(7'h6B, ok);
    chk("R2 no ack before power good", ok, 0);
  endtask

  task automatic t_addr_levels();
    logic ok;
    do_reset(2'b01); pulse_pg();
    probe(7'h6C, ok); chk("R1 mid address", ok, 1);
    probe(7'h6B, ok); chk("R3 wrong address", ok, 0);
    do_reset(2'b10); pulse_pg();
    probe(7'h6D, ok); chk("R1 high address", ok, 1);
    do_reset(2'b00); pulse_pg();
    probe(7'h6B, ok); chk("R1 low address", ok, 1);
    addr_sel = 2'b10;
    pwr_good = 1'b0; repeat (8) @(negedge clk);
    pulse_pg();
    probe(7'h6B, ok); chk("R2 latched once", ok, 1);
    probe(7'h6D, ok); chk("R2 later select ignored", ok, 0);
  endtask

  task automatic t_write_read();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    blk_write(7'h6B, 8'd2, 8'd3, 3);
    chk("R4 addr ack", addr_ack, 1);
    chk("R4 data acks", {wack[0], wack[1], wack[2]}, 3'b111);
    chk("R4 byte2", cbyte(2), 8'hA1);
    chk("R4 byte3", cbyte(3), 8'hB2);
    chk("R4 byte4", cbyte(4), 8'hC3);
    blk_read(7'h6B, 8'd2, 3);
    chk("R6 count byte default", rcount, 8'h08);
    chk("R6 read order", {rbuf[0], rbuf[1], rbuf[2]}, 24'hA1B2C3);
    // R3: mismatched address writes nothing
    wbuf[0] = 8'h77;
    blk_write(7'h6D, 8'd2, 8'd1, 1);
    chk("R3 no write on mismatch", cbyte(2), 8'hA1);
  endtask

  task automatic t_overcount();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    blk_write(7'h6B, 8'd10, 8'd2, 3);
    chk("R5 in-count acks", {wack[0], wack[1]}, 2'b11);
    chk("R5 extra byte nacked", wack[2], 0);
    chk("R5 extra byte not stored", cbyte(12), 8'h00);
    chk("R11 index advance", cbyte(11), 8'h22);
  endtask

  task automatic t_count_reg();
    wbuf[0] = 8'hE3;
    blk_write(7'h6B, 8'd7, 8'd1, 1);
    chk("R7 count write masked", cbyte(7), 8'h03);
    blk_read(7'h6B, 8'd2, 4);
    chk("R6 count byte", rcount, 8'h03);
    chk("R6 data bytes", {rbuf[0], rbuf[1], rbuf[2]}, 24'hA1B2C3);
    chk("R6 past count reads FF", rbuf[3], 8'hFF);
  endtask

  task automatic t_readonly();
    wbuf[0] = 8'h00;
    blk_write(7'h6B, 8'd5, 8'd1, 1);
    chk("R8 id write ack", wack[0], 1);
    chk("R8 id unchanged", cbyte(5), 8'h11);
    wbuf[0] = 8'hFF;
    blk_write(7'h6B, 8'd17, 8'd1, 1);
    chk("R8 byte17 zero", cbyte(17), 8'h00);
    wbuf[0] = 8'hFF;
    stat_in = 2'b10;
    blk_write(7'h6B, 8'd1, 8'd1, 1);
    chk("R9 live bits with write", cbyte(1), 8'hBF);
    stat_in = 2'b01;
    repeat (2) @(negedge clk);
    chk("R9 live bits follow input", cbyte(1), 8'h7F);
    blk_read(7'h6B, 8'd1, 1);
    chk("R9 live bits on bus", rbuf[0], 8'h7F);
  endtask

  task automatic t_out_of_range();
    wbuf[0] = 8'h01;
    blk_write(7'h6B, 8'd7, 8'd1, 1);
    wbuf[0] = 8'h55;
    blk_write(7'h6B, 8'd30, 8'd1, 1);
    chk("R11 out of range ack", wack[0], 1);
    blk_read(7'h6B, 8'd30, 1);
    chk("R11 count byte", rcount, 8'h01);
    chk("R11 out of range reads 0", rbuf[0], 8'h00);
  endtask

  task automatic t_abort();
    logic k, s;
    // STOP after four bits of the second data byte
    host_start();
    send_byte({7'h6B, 1'b0}, k);
    send_byte(8'd8, k);
    send_byte(8'd3, k);
    send_byte(8'h5A, k);
    for (int i = 0; i < 4; i++) host_bit(1'b1, s);
    host_stop();
    chk("R10 full byte stored", cbyte(8), 8'h5A);
    chk("R10 partial byte dropped on stop", cbyte(9), 8'h00);
    // repeated START after three bits, then a read
    host_start();
    send_byte({7'h6B, 1'b0}, k);
    send_byte(8'd9, k);
    send_byte(8'd1, k);
    for (int i = 0; i < 3; i++) host_bit(1'b1, s);
    host_start();
    send_byte({7'h6B, 1'b1}, k);
    chk("R10 address phase after restart", k, 1);
    recv_byte(1'b1, rcount);
    host_stop();
    chk("R10 count byte after restart", rcount, 8'h01);
    chk("R10 partial byte dropped on restart", cbyte(9), 8'h00);
    chk("R12 sda released at end", sda_drive_low, 0);
  endtask

  initial begin
    t_reset();
    t_addr_levels();
    t_write_read();
    t_overcount();
    t_count_reg();
    t_readonly();
    t_out_of_range();
    t_abort();
    chk("R12 no SDA change with SCL high", r12_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule